// File: doc/BRIEF.md
# CAN Receive FIFO Element Writer

This block sits behind the acceptance filter of a CAN / CAN FD receiver. Each frame offered on its input handshake is directed to one of two receive FIFOs. Both FIFOs live in a shared message memory that is 32 bits wide and addressed by word. The block turns the frame into one element: two header words, then a configurable number of payload words. It writes the element into the memory one word per cycle through a single write port.

For each FIFO the block keeps a put index, a get index, a fill level, a full flag and a sticky lost flag. The host frees elements by writing an acknowledge index. The FIFO's start address, its depth and its payload width come in as configuration inputs.

The receive timestamp is captured when the frame is accepted. It comes either from an internal 16-bit counter that advances on a bit-time tick, or from an external 16-bit vector.

Top module: `can_rxfifo_writer`

## Requirements
- R1: After reset, every FIFO has fill level 0, put and get indices 0, full and lost low, `frm_ready` high, and no memory write is issued.
- R2: Header word 0 holds the error-state flag in bit 31 (1 = sender error passive) and the identifier type in bit 30 (1 = 29-bit ID). A 29-bit ID occupies bits 28:0. An 11-bit ID occupies bits 28:18, with bits 17:0 zero.
- R3: Bit 29 of header word 0 is `frm_rtr` for a classic frame (`frm_fdf` = 0). It is `frm_rrs` for an FD frame, and in that case `frm_rtr` has no effect.
- R4: Header word 1 holds the timestamp in bits 15:0, the DLC in bits 19:16 and the FD flag in bit 21. All other bits are zero.
- R5: The timestamp is the internal tick counter value at the accepting clock edge when `ts_sel_ext` = 0, and `ts_ext` when `ts_sel_ext` = 1. The counter resets to 0 and adds one on each edge where `ts_tick` is high.
- R6: An element is 2 + D words, where D is the FIFO's `cfg_dwords` value limited to 1..MAX_DWORDS. Word k ≥ 2 carries frame data word k−2. The words are written on consecutive cycles in order of k, starting the cycle after acceptance.
- R7: Word k of an element goes to address `cfg_start[15:2]` + put_index × (2 + D) + k. Bits 1:0 of `cfg_start` are ignored.
- R8: The put index advances by one per stored element and wraps to 0 after element `cfg_size`−1.
- R9: `full` is high while the fill level equals `cfg_size`. A frame accepted for a full FIFO produces no memory write and leaves the indices unchanged. It sets that FIFO's lost flag, which stays set until reset.
- R10: An acknowledge of an occupied index i sets the get index to (i+1) mod `cfg_size`. It lowers the fill level by the number of elements from the get index through i. An acknowledge of an index that holds no stored element changes nothing.
- R11: `frm_sel` and `ack_sel` choose FIFO 0 or 1. Activity on one FIFO leaves the other FIFO's indices, fill level and flags unchanged.
- R12: `frm_ready` is low while an element is being written. The fill level rises by one at the clock edge that writes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Accepted frame offered |
| frm_ready | output | 1 | Block idle and able to take a frame |
| frm_sel | input | 1 | Target FIFO |
| frm_esi | input | 1 | Sender error-passive flag |
| frm_xtd | input | 1 | 29-bit identifier |
| frm_rtr | input | 1 | Remote frame (classic only) |
| frm_fdf | input | 1 | FD frame |
| frm_rrs | input | 1 | Remote-substitution bit of an FD frame |
| frm_id | input | 29 | Identifier, right-aligned |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 32·MAX_DWORDS | Payload, word j in bits 32j+31:32j |
| ts_tick | input | 1 | Bit-time tick for the internal counter |
| ts_sel_ext | input | 1 | Select the external timestamp |
| ts_ext | input | 16 | External timestamp vector |
| cfg_start | input | 2×16 | Per-FIFO start byte address |
| cfg_size | input | 2×7 | Per-FIFO depth in elements (0..64) |
| cfg_dwords | input | 2×5 | Per-FIFO payload words per element |
| ack_we | input | 1 | Host acknowledge strobe |
| ack_sel | input | 1 | FIFO being acknowledged |
| ack_idx | input | 6 | Index of the last element read |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| fill | output | 2×7 | Per-FIFO fill level |
| full | output | 2 | Per-FIFO full flag |
| lost | output | 2 | Per-FIFO sticky lost flag |
| put_idx | output | 2×6 | Per-FIFO put index |
| get_idx | output | 2×6 | Per-FIFO get index |

## Verification
The bench fills a three-deep FIFO to the limit and offers one more frame. A design that misjudged fullness would overwrite the oldest element or fail to raise the lost flag. It sends an FD frame with the remote bit set and the substitution bit clear. A design that always copied the remote bit would show bit 29 set. The next frame after the third element must land at index 0, at the start address whose low byte-address bits are nonzero. A wrong wrap or an unmasked address shows up as a wrong write address. An acknowledge that releases two elements at once is followed by a stale acknowledge. A design that freed a fixed count, or did not reject the stale index, would drift its fill level.

// File: rtl/can_rxw_pkg.sv
package can_rxw_pkg;

  localparam int IDX_W   = 6;
  localparam int FILL_W  = 7;
  localparam int WADDR_W = 14;
  localparam int TS_W    = 16;

  function automatic logic [5:0] elem_words(input logic [4:0] dw, input int maxdw);
    int d;
    d = int'(dw);
    if (d == 0) d = 1;
    if (d > maxdw) d = maxdw;
    return 6'(d + 2);
  endfunction

  function automatic logic [WADDR_W-1:0] elem_base(input logic [13:0] start_w,
                                                   input logic [IDX_W-1:0] put,
                                                   input logic [5:0] ew);
    return start_w + WADDR_W'(put) * WADDR_W'(ew);
  endfunction

  function automatic logic [31:0] hdr_word0(input logic esi, input logic xtd,
                                            input logic rtr, input logic fdf,
                                            input logic rrs, input logic [28:0] id);
    logic [28:0] idf;
    idf = xtd ? id : {id[10:0], 18'b0};
    return {esi, xtd, (fdf ? rrs : rtr), idf};
  endfunction

  function automatic logic [31:0] hdr_word1(input logic [TS_W-1:0] ts,
                                            input logic [3:0] dlc, input logic fdf);
    return {10'b0, fdf, 1'b0, dlc, ts};
  endfunction

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] idx,
                                                input logic [FILL_W-1:0] size);
    return ((FILL_W'(idx) + 7'd1) >= size) ? '0 : idx + 6'd1;
  endfunction

  function automatic logic [FILL_W-1:0] release_count(input logic [IDX_W-1:0] get,
                                                      input logic [IDX_W-1:0] ack,
                                                      input logic [FILL_W-1:0] size);
    logic [7:0] g, a, s;
    g = 8'(get);
    a = 8'(ack);
    s = 8'(size);
    if (a >= g) return FILL_W'(a - g + 8'd1);
    else        return FILL_W'(a + s - g + 8'd1);
  endfunction

endpackage

// File: rtl/rxw_tstamp.sv
module rxw_tstamp
  import can_rxw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            sel_ext,
  input  logic [TS_W-1:0] ext,
  output logic [TS_W-1:0] ts_now
);
  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign ts_now = sel_ext ? ext : cnt_q;
endmodule

// File: rtl/rxw_fifo_ctl.sv
module rxw_fifo_ctl
  import can_rxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] size,
  input  logic              push,
  input  logic              drop,
  input  logic              ack_we,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic [IDX_W-1:0]  put_q,
  output logic [IDX_W-1:0]  get_q,
  output logic [FILL_W-1:0] fill_q,
  output logic              full,
  output logic              lost_q
);
  logic [FILL_W-1:0] rel;
  logic              ack_ok;
  logic [FILL_W-1:0] dec;

  assign rel    = release_count(get_q, ack_idx, size);
  assign ack_ok = ack_we && (FILL_W'(ack_idx) < size) && (fill_q != '0) && (rel <= fill_q);
  assign dec    = ack_ok ? rel : '0;
  assign full   = (fill_q >= size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      put_q  <= '0;
      get_q  <= '0;
      fill_q <= '0;
      lost_q <= 1'b0;
    end else begin
      if (push)   put_q <= next_idx(put_q, size);
      if (ack_ok) get_q <= next_idx(ack_idx, size);
      fill_q <= fill_q + FILL_W'(push) - dec;
      if (drop)   lost_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxw_elem_writer.sv
module rxw_elem_writer
  import can_rxw_pkg::*;
#(
  parameter int MAX_DWORDS = 16,
  parameter int SEL_W      = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [SEL_W-1:0]        go_sel,
  input  logic [31:0]             hdr0_in,
  input  logic [31:0]             hdr1_in,
  input  logic [MAX_DWORDS*32-1:0] data_in,
  input  logic [WADDR_W-1:0]      base_in,
  input  logic [5:0]              ew_in,
  output logic                    busy,
  output logic                    done,
  output logic [SEL_W-1:0]        done_sel,
  output logic                    mem_we,
  output logic [WADDR_W-1:0]      mem_addr,
  output logic [31:0]             mem_wdata
);
  localparam int DIX_W = (MAX_DWORDS > 1) ? $clog2(MAX_DWORDS) : 1;

  logic [31:0]         dw_q [MAX_DWORDS];
  logic [31:0]         h0_q, h1_q;
  logic [WADDR_W-1:0]  base_q;
  logic [5:0]          ew_q, k_q;
  logic [SEL_W-1:0]    sel_q;
  logic [5:0]          didx;

  generate
    for (genvar j = 0; j < MAX_DWORDS; j++) begin : g_lat
      always_ff @(posedge clk) begin
        if (go) dw_q[j] <= data_in[j*32 +: 32];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      k_q    <= '0;
      ew_q   <= 6'd3;
      base_q <= '0;
      h0_q   <= '0;
      h1_q   <= '0;
      sel_q  <= '0;
    end else if (go) begin
      busy   <= 1'b1;
      k_q    <= '0;
      ew_q   <= ew_in;
      base_q <= base_in;
      h0_q   <= hdr0_in;
      h1_q   <= hdr1_in;
      sel_q  <= go_sel;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      k_q  <= k_q + 6'd1;
    end
  end

  assign didx      = k_q - 6'd2;
  assign done      = busy && (k_q == ew_q - 6'd1);
  assign done_sel  = sel_q;
  assign mem_we    = busy;
  assign mem_addr  = base_q + WADDR_W'(k_q);
  assign mem_wdata = (k_q == 6'd0) ? h0_q :
                     (k_q == 6'd1) ? h1_q : dw_q[didx[DIX_W-1:0]];

  logic unused_hi;
  assign unused_hi = ^didx;
endmodule

// File: rtl/can_rxfifo_writer.sv
module can_rxfifo_writer
  import can_rxw_pkg::*;
#(
  parameter int NUM_FIFO   = 2,
  parameter int MAX_DWORDS = 16,
  localparam int SEL_W     = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frm_valid,
  output logic                               frm_ready,
  input  logic [SEL_W-1:0]                   frm_sel,
  input  logic                               frm_esi,
  input  logic                               frm_xtd,
  input  logic                               frm_rtr,
  input  logic                               frm_fdf,
  input  logic                               frm_rrs,
  input  logic [28:0]                        frm_id,
  input  logic [3:0]                         frm_dlc,
  input  logic [MAX_DWORDS*32-1:0]           frm_data,
  input  logic                               ts_tick,
  input  logic                               ts_sel_ext,
  input  logic [15:0]                        ts_ext,
  input  logic [NUM_FIFO-1:0][15:0]          cfg_start,
  input  logic [NUM_FIFO-1:0][6:0]           cfg_size,
  input  logic [NUM_FIFO-1:0][4:0]           cfg_dwords,
  input  logic                               ack_we,
  input  logic [SEL_W-1:0]                   ack_sel,
  input  logic [5:0]                         ack_idx,
  output logic                               mem_we,
  output logic [13:0]                        mem_addr,
  output logic [31:0]                        mem_wdata,
  output logic [NUM_FIFO-1:0][6:0]           fill,
  output logic [NUM_FIFO-1:0]                full,
  output logic [NUM_FIFO-1:0]                lost,
  output logic [NUM_FIFO-1:0][5:0]           put_idx,
  output logic [NUM_FIFO-1:0][5:0]           get_idx
);
  logic [TS_W-1:0]    ts_now;
  logic               busy;
  logic               ev_accept, ev_drop, ev_go, ev_done;
  logic [SEL_W-1:0]   done_sel;
  logic [5:0]         sel_ew;
  logic [WADDR_W-1:0] sel_base;
  logic [31:0]        h0, h1;

  rxw_tstamp u_ts (
    .clk(clk), .rst_n(rst_n), .tick(ts_tick), .sel_ext(ts_sel_ext),
    .ext(ts_ext), .ts_now(ts_now)
  );

  assign frm_ready = !busy;
  assign ev_accept = frm_valid && frm_ready;
  assign ev_drop   = ev_accept && full[frm_sel];
  assign ev_go     = ev_accept && !full[frm_sel];

  assign sel_ew   = elem_words(cfg_dwords[frm_sel], MAX_DWORDS);
  assign sel_base = elem_base(cfg_start[frm_sel][15:2], put_idx[frm_sel], sel_ew);
  assign h0       = hdr_word0(frm_esi, frm_xtd, frm_rtr, frm_fdf, frm_rrs, frm_id);
  assign h1       = hdr_word1(ts_now, frm_dlc, frm_fdf);

  generate
    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
      logic push_i, drop_i, ack_i;
      assign push_i = ev_done && (done_sel == SEL_W'(i));
      assign drop_i = ev_drop && (frm_sel == SEL_W'(i));
      assign ack_i  = ack_we && (ack_sel == SEL_W'(i));
      rxw_fifo_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .size(cfg_size[i]), .push(push_i),
        .drop(drop_i), .ack_we(ack_i), .ack_idx(ack_idx),
        .put_q(put_idx[i]), .get_q(get_idx[i]), .fill_q(fill[i]),
        .full(full[i]), .lost_q(lost[i])
      );
    end
  endgenerate

  rxw_elem_writer #(.MAX_DWORDS(MAX_DWORDS), .SEL_W(SEL_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(ev_go), .go_sel(frm_sel),
    .hdr0_in(h0), .hdr1_in(h1), .data_in(frm_data), .base_in(sel_base),
    .ew_in(sel_ew), .busy(busy), .done(ev_done), .done_sel(done_sel),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic unused_start;
  always_comb begin
    unused_start = 1'b0;
    for (int i = 0; i < NUM_FIFO; i++) unused_start = unused_start ^ (^cfg_start[i][1:0]);
  end
endmodule

// File: rtl/can_rxfifo_writer_checker.sv
module can_rxfifo_writer_checker #(
  parameter int NUM_FIFO = 2,
  parameter int SEL_W    = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frm_ready,
  input logic                     mem_we,
  input logic                     ev_accept,
  input logic                     ev_drop,
  input logic                     ev_done,
  input logic [SEL_W-1:0]         done_sel,
  input logic                     ack_we,
  input logic [SEL_W-1:0]         ack_sel,
  input logic [NUM_FIFO-1:0][6:0] cfg_size,
  input logic [NUM_FIFO-1:0][6:0] fill,
  input logic [NUM_FIFO-1:0]      lost,
  input logic [NUM_FIFO-1:0][5:0] put_idx
);
  p_ready_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> !mem_we);

  p_drop_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !mem_we);

  p_accept_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_drop) |=> mem_we);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill[0] <= cfg_size[0]);

  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lost[0] |=> lost[0]);

  p_put_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && done_sel == '0 && 7'(put_idx[0]) == cfg_size[0] - 7'd1) |=> put_idx[0] == 6'd0);

  p_fill_up_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && done_sel == '0 && !(ack_we && ack_sel == '0)) |=> fill[0] == $past(fill[0]) + 7'd1);
endmodule

bind can_rxfifo_writer can_rxfifo_writer_checker #(.NUM_FIFO(NUM_FIFO), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_ready(frm_ready), .mem_we(mem_we),
  .ev_accept(ev_accept), .ev_drop(ev_drop), .ev_done(ev_done), .done_sel(done_sel),
  .ack_we(ack_we), .ack_sel(ack_sel), .cfg_size(cfg_size), .fill(fill),
  .lost(lost), .put_idx(put_idx)
);

// File: tb/can_rxfifo_writer_bench.sv
module can_rxfifo_writer_bench;
  localparam int NF = 2;
  localparam int MD = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, frm_valid, frm_ready, frm_esi, frm_xtd, frm_rtr, frm_fdf, frm_rrs;
  logic [0:0] frm_sel, ack_sel;
  logic [28:0] frm_id;
  logic [3:0] frm_dlc;
  logic [MD*32-1:0] frm_data;
  logic ts_tick, ts_sel_ext;
  logic [15:0] ts_ext;
  logic [NF-1:0][15:0] cfg_start;
  logic [NF-1:0][6:0] cfg_size;
  logic [NF-1:0][4:0] cfg_dwords;
  logic ack_we;
  logic [5:0] ack_idx;
  logic mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [NF-1:0][6:0] fill;
  logic [NF-1:0] full, lost;
  logic [NF-1:0][5:0] put_idx, get_idx;

  can_rxfifo_writer u_can_rxfifo_writer (.*);

  int tests = 0, fails = 0, writes = 0, bench_ts = 0;
  int m_put[NF], m_get[NF], m_fill[NF], m_lost[NF];
  int q_addr[$];
  int unsigned q_data[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && ts_tick) bench_ts <= bench_ts + 1;

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      writes++;
      if (q_addr.size() == 0) check(0, "R9 unexpected write", mem_addr, 0);
      else begin
        int a; int unsigned d; string t;
        a = q_addr.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
        check(mem_addr == 14'(a), {"R7 addr ", t}, mem_addr, a);
        check(mem_wdata == d, {t, " data"}, mem_wdata, d);
      end
    end
  end

  function automatic int ew_of(int s);
    return cfg_dwords[s] + 2;
  endfunction

  task automatic send(input int s, input bit esi, input bit xtd, input bit rtr,
                      input bit fdf, input bit rrs, input int id, input int dlc,
                      input bit ext_sel, input int extv, input int tagno);
    int ts, ew;
    int unsigned w0, w1;
    ew = ew_of(s);
    @(negedge clk);
    check(frm_ready == 1'b1, "R12 ready idle", frm_ready, 1);
    frm_valid = 1; frm_sel = 1'(s); frm_esi = esi; frm_xtd = xtd; frm_rtr = rtr;
    frm_fdf = fdf; frm_rrs = rrs; frm_id = 29'(id); frm_dlc = 4'(dlc);
    ts_sel_ext = ext_sel; ts_ext = 16'(extv);
    for (int j = 0; j < MD; j++) frm_data[j*32 +: 32] = 32'hA000_0000 + 32'(tagno * 256 + j);
    ts = ext_sel ? extv : (bench_ts & 16'hFFFF);
    if (m_fill[s] >= cfg_size[s]) m_lost[s] = 1;
    else begin
      int base;
      base = (cfg_start[s] >> 2) + m_put[s] * ew;
      w0 = (32'(esi) << 31) | (32'(xtd) << 30) | (32'(fdf ? rrs : rtr) << 29) |
           (xtd ? (32'(id) & 32'h1FFF_FFFF) : ((32'(id) & 32'h7FF) << 18));
      w1 = 32'(ts) | (32'(dlc) << 16) | (32'(fdf) << 21);
      q_addr.push_back(base);     q_data.push_back(w0); q_tag.push_back("R2/R3 hdr0");
      q_addr.push_back(base + 1); q_data.push_back(w1); q_tag.push_back("R4/R5 hdr1");
      for (int j = 0; j < ew - 2; j++) begin
        q_addr.push_back(base + 2 + j);
        q_data.push_back(32'hA000_0000 + 32'(tagno * 256 + j));
        q_tag.push_back("R6 payload");
      end
      m_put[s] = (m_put[s] + 1) % cfg_size[s];
      m_fill[s]++;
    end
    @(negedge clk);
    frm_valid = 0;
    repeat (ew + 2) @(negedge clk);
    check(q_addr.size() == 0, "R6 all words written", q_addr.size(), 0);
  endtask

  task automatic do_ack(input int s, input int idx);
    int cnt;
    cnt = 0;
    @(negedge clk);
    ack_we = 1; ack_sel = 1'(s); ack_idx = 6'(idx);
    for (int j = 0; j < m_fill[s]; j++)
      if ((m_get[s] + j) % cfg_size[s] == idx && cnt == 0) cnt = j + 1;
    if (cnt != 0) begin
      m_fill[s] -= cnt;
      m_get[s] = (idx + 1) % cfg_size[s];
    end
    @(negedge clk);
    ack_we = 0;
  endtask

  task automatic check_state(input string tag);
    for (int s = 0; s < NF; s++) begin
      check(fill[s] == 7'(m_fill[s]), {tag, " fill"}, fill[s], m_fill[s]);
      check(put_idx[s] == 6'(m_put[s]), {tag, " put"}, put_idx[s], m_put[s]);
      check(get_idx[s] == 6'(m_get[s]), {tag, " get"}, get_idx[s], m_get[s]);
      check(lost[s] == 1'(m_lost[s]), {tag, " lost"}, lost[s], m_lost[s]);
      check(full[s] == (m_fill[s] >= cfg_size[s]), {tag, " full"}, full[s], m_fill[s] >= cfg_size[s]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wbefore;
    rst_n = 0; frm_valid = 0; frm_sel = 0; frm_esi = 0; frm_xtd = 0; frm_rtr = 0;
    frm_fdf = 0; frm_rrs = 0; frm_id = 0; frm_dlc = 0; frm_data = '0;
    ts_tick = 1; ts_sel_ext = 0; ts_ext = 0; ack_we = 0; ack_sel = 0; ack_idx = 0;
    cfg_start[0] = 16'h0106; cfg_start[1] = 16'h0403;
    cfg_size[0] = 7'd3; cfg_size[1] = 7'd5;
    cfg_dwords[0] = 5'd2; cfg_dwords[1] = 5'd4;
    for (int s = 0; s < NF; s++) begin m_put[s] = 0; m_get[s] = 0; m_fill[s] = 0; m_lost[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(frm_ready == 1 && mem_we == 0, "R1 reset ready/no write", {frm_ready, mem_we}, 2'b10);
    check_state("R1 reset");

    // R2 R3 R5: classic standard remote frame, internal timestamp, FIFO 0
    send(0, 1, 0, 1, 0, 0, 29'h5A3, 4, 0, 0, 1);
    check_state("R12 after elem");
    // R3: FD extended frame, rtr ignored, rrs used
    send(0, 0, 1, 1, 1, 0, 29'h1ABC_DE01, 15, 0, 0, 2);
    // R5 R11: external timestamp into FIFO 1
    send(1, 0, 1, 0, 1, 1, 29'h0123_4567, 9, 1, 16'hBEEF, 3);
    check_state("R11 independent");
    // R9: fill FIFO 0
    send(0, 0, 0, 0, 0, 0, 29'h7FF, 8, 0, 0, 4);
    check_state("R9 full");
    wbefore = writes;
    send(0, 1, 1, 1, 1, 1, 29'h1, 1, 0, 0, 5);
    check(writes == wbefore, "R9 drop no write", writes - wbefore, 0);
    check_state("R9 lost");
    // R10: release two at once, then a stale acknowledge
    do_ack(0, 1);
    @(negedge clk);
    check_state("R10 ack two");
    do_ack(0, 1);
    @(negedge clk);
    check_state("R10 stale ack");
    // R8: next element wraps to index 0
    send(0, 0, 0, 0, 0, 0, 29'h100, 2, 0, 0, 6);
    check_state("R8 wrap");
    send(0, 1, 0, 0, 0, 0, 29'h101, 3, 1, 16'h0042, 7);
    check_state("R8 second");
    do_ack(1, 0);
    @(negedge clk);
    check_state("R10 fifo1 ack");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule